// File: doc/BRIEF.md
# Digital Audio Transmit Control Registers and Sample FIFO

This block sits between a system register bus and the frame encoder of a consumer digital audio transmitter. Software programs it through 32-bit word-addressed registers with a 4-byte stride. These registers cover global control, transmit configuration, FIFO control and status, interrupt enable and status, a transmitted-sample counter and two channel-status words. Audio samples arrive as 16-bit writes from a DMA engine, which moves bursts of four. Samples can also be written through a FIFO data register. They queue in a parameterised FIFO until the encoder pulls them.

A DMA request is raised while the FIFO level is at or below a programmable trigger level. The encoder receives the head sample, an "active" qualifier, the configuration word and both channel-status words. Transmission depends on three separate controls: a self-clearing soft reset, a self-clearing FIFO flush, and a global enable. The global enable gates both the transmit enable and the DMA request enable. Software brings the block up in this order: soft reset, then flush, then clearing the sample counter. It then sets transmit enable, DMA request enable and global enable, and it clears the same bits to stop.

Top module: `aud_tx_ctrl`

## Requirements
- R1: After reset every register reads zero, with two exceptions. FIFO status (0x18) reads 0x6000 with the default depth of 32. Interrupt status (0x20) reads 0x10, because the low-level condition holds. `dma_req`, `irq` and `enc_sample` are 0.
- R2: In control (0x00), bit 1 is global enable and bit 2 drives `mclk_oe`. Bits [7:4] hold the master clock divider. The divider's bit 4 is always stored as 0, so an odd value becomes the next lower even one. The stored divider appears on `mclk_div`.
- R3: Writing 1 to control bit 0 starts a soft reset. The bit reads back 1 for one cycle only. On the following clock the FIFO empties, the sample counter becomes 0 and all interrupt status bits become 0. All other register fields keep their values.
- R4: Writing 1 to FIFO control (0x14) bit 17 flushes the FIFO. The bit reads back 1 for one cycle only. On the following clock the FIFO empties, and the sample counter and the other FIFO control fields are kept.
- R5: FIFO control bit 2 selects how a 16-bit DMA word is placed. When it is 0 the word lands in the upper 16 bits of the sample and the low bits are zero. When it is 1 the word is zero-extended. A bus write to 0x0C pushes `bus_wdata[SAMPLE_W-1:0]` unchanged. If a DMA write and a bus write to 0x0C fall in the same cycle, only the DMA sample is stored.
- R6: Samples leave on `enc_sample` in the order they were written, one per `enc_pull` cycle. A pull has effect only while both control bit 1 and configuration (0x04) bit 0 are set. At any other time it leaves the FIFO level and the counter unchanged.
- R7: In FIFO status, bit 14 reads 1 while at least one entry is free. Bits [13:8] give the number of free entries.
- R8: `dma_req` is high while all three conditions hold: control bit 1 is set, interrupt enable (0x1C) bit 7 is set, and the fill level is at or below the trigger level in FIFO control bits [12:8].
- R9: A push into a full FIFO with no pull in the same cycle is discarded, and interrupt status bit 5 (overrun) is set. A push and a pull in the same cycle on a full FIFO are both accepted, and no overrun is flagged.
- R10: A pull while transmission is active and the FIFO is empty has four effects. `enc_sample` reads 0, interrupt status bit 6 (underrun) is set, and the counter and level stay unchanged.
- R11: Interrupt status bit 4 is set on every cycle in which the fill level is at or below the trigger level. Writing 1 to a status bit clears it and writing 0 leaves it alone. If a set condition and a clear fall in the same cycle, the set wins.
- R12: `irq` is the OR of interrupt status bits 6:4, each masked by the interrupt enable bit in the same position.
- R13: The counter at 0x24 increases by one for each sample the encoder takes. A bus write loads the written value into it, so writing 0 clears it.
- R14: Configuration (0x04) keeps only bits 31, 17, 16 and 8:0, and its other bits read 0. Its value is output on `enc_cfg`. The channel-status words at 0x2C and 0x30 are read/write and are output on `enc_cs0` and `enc_cs1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| dma_we | input | 1 | DMA sample write strobe |
| dma_wdata | input | 16 | DMA sample |
| dma_req | output | 1 | DMA request |
| enc_pull | input | 1 | Encoder takes one sample |
| enc_sample | output | SAMPLE_W | Head sample, or 0 when the FIFO is empty |
| enc_active | output | 1 | Global enable AND transmit enable |
| enc_cfg | output | 32 | Transmit configuration word |
| enc_cs0 | output | 32 | Channel-status word 0 |
| enc_cs1 | output | 32 | Channel-status word 1 |
| mclk_oe | output | 1 | Master clock output enable |
| mclk_div | output | DIV_W | Even master clock divider |
| irq | output | 1 | Interrupt |

## Verification
Two functions can fall in the same cycle: a FIFO write and an encoder pull. The bench fills the FIFO to its last entry, then raises a DMA write and `enc_pull` on the same clock. It judges the result by the absence of the overrun flag, an unchanged free count of zero, and the sample that follows. The opposite boundary is also provoked: a pull on an empty, active FIFO must return zero and set underrun. The bench also raises a DMA write and a bus FIFO write together and checks that the DMA word alone is stored.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;
   // register byte offsets
   localparam int unsigned OFS_CTRL = 32'h00;
   localparam int unsigned OFS_CFG  = 32'h04;
   localparam int unsigned OFS_FIFO = 32'h0C;
   localparam int unsigned OFS_FCTL = 32'h14;
   localparam int unsigned OFS_FSTA = 32'h18;
   localparam int unsigned OFS_IEN  = 32'h1C;
   localparam int unsigned OFS_ISTA = 32'h20;
   localparam int unsigned OFS_CNT  = 32'h24;
   localparam int unsigned OFS_CS0  = 32'h2C;
   localparam int unsigned OFS_CS1  = 32'h30;

   // field positions
   localparam int unsigned CTRL_RST     = 0;
   localparam int unsigned CTRL_GEN     = 1;
   localparam int unsigned CTRL_MCLK    = 2;
   localparam int unsigned CTRL_DIV_LSB = 4;
   localparam int unsigned CFG_TXEN     = 0;
   localparam logic [31:0] CFG_WMASK    = 32'h8003_01FF;
   localparam int unsigned FCTL_FLUSH    = 17;
   localparam int unsigned FCTL_TRIG_LSB = 8;
   localparam int unsigned FCTL_IMODE    = 2;
   localparam int unsigned FSTA_SPACE    = 14;
   localparam int unsigned FSTA_FREE_LSB = 8;
   localparam int unsigned IRQ_DRQ = 7;
   localparam int unsigned IRQ_UND = 6;
   localparam int unsigned IRQ_OVR = 5;
   localparam int unsigned IRQ_LOW = 4;

   // event vector order: [2] underrun, [1] overrun, [0] low level
   typedef struct packed {
      logic under;
      logic over;
      logic low;
   } tx_evt_t;
endpackage

// File: rtl/aud_tx_fifo.sv
`timescale 1ns/1ps
module aud_tx_fifo #(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned FILL_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                push,
   input  logic [SAMPLE_W-1:0] push_data,
   input  logic                pull,
   output logic [SAMPLE_W-1:0] head,
   output logic [FILL_W-1:0]   fill,
   output logic                pop_ok,
   output logic                overrun,
   output logic                underrun
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0]  LAST = PTR_W'(DEPTH - 1);
   localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

   logic [SAMPLE_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]    wp, rp;
   logic [FILL_W-1:0]   cnt;
   logic                push_ok;
   logic                empty;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == LAST) ? '0 : p + PTR_W'(1);
   endfunction

   assign empty    = (cnt == '0);
   assign pop_ok   = pull & ~empty & ~clr;
   assign push_ok  = push & ~clr & ((cnt != FULL) | pop_ok);
   assign overrun  = push & ~clr & ~push_ok;
   assign underrun = pull & ~clr & empty;
   assign fill     = cnt;
   assign head     = empty ? '0 : mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= step(wp);
         if (pop_ok)  rp <= step(rp);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + FILL_W'(1);
            2'b01:   cnt <= cnt - FILL_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= push_data;
   end
endmodule

// File: rtl/aud_tx_irq.sv
`timescale 1ns/1ps
module aud_tx_irq
   import aud_tx_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clr,
   input  tx_evt_t evt,
   input  tx_evt_t w1c,
   input  tx_evt_t ie,
   output tx_evt_t sta,
   output logic    irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sta <= '0;
      else if (clr) sta <= '0;
      else          sta <= (sta & ~w1c) | evt;
   end

   assign irq = |(sta & ie);
endmodule

// File: rtl/aud_tx_regs.sv
`timescale 1ns/1ps
module aud_tx_regs
   import aud_tx_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DEPTH   = 32,
   parameter int unsigned FILL_W  = 6,
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned TRIG_W  = 5,
   parameter int unsigned TXCNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [FILL_W-1:0]  fill,
   input  tx_evt_t            sta,
   input  logic               pop,
   output logic               glob_en,
   output logic               mclk_oe,
   output logic [DIV_W-1:0]   mclk_div,
   output logic [31:0]        tx_cfg,
   output logic [TRIG_W-1:0]  trig,
   output logic               imode,
   output tx_evt_t            ie,
   output logic               drq_en,
   output logic [31:0]        cs0,
   output logic [31:0]        cs1,
   output logic               soft_rst,
   output logic               flush,
   output tx_evt_t            w1c,
   output logic               fifo_we,
   output logic [TXCNT_W-1:0] tx_count
);
   logic we_ctrl, we_cfg, we_fctl, we_ien, we_ista, we_cnt, we_cs0, we_cs1;
   logic [DIV_W-2:0]  div_hi;
   logic [FILL_W-1:0] free;

   assign we_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign we_cfg  = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
   assign fifo_we = bus_we && (bus_addr == ADDR_W'(OFS_FIFO));
   assign we_fctl = bus_we && (bus_addr == ADDR_W'(OFS_FCTL));
   assign we_ien  = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
   assign we_ista = bus_we && (bus_addr == ADDR_W'(OFS_ISTA));
   assign we_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_CNT));
   assign we_cs0  = bus_we && (bus_addr == ADDR_W'(OFS_CS0));
   assign we_cs1  = bus_we && (bus_addr == ADDR_W'(OFS_CS1));

   assign mclk_div = {div_hi, 1'b0};
   assign free     = FILL_W'(DEPTH) - fill;

   always_comb begin
      w1c = '0;
      if (we_ista) begin
         w1c.under = bus_wdata[IRQ_UND];
         w1c.over  = bus_wdata[IRQ_OVR];
         w1c.low   = bus_wdata[IRQ_LOW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_rst <= 1'b0;
         flush    <= 1'b0;
         glob_en  <= 1'b0;
         mclk_oe  <= 1'b0;
         div_hi   <= '0;
         tx_cfg   <= '0;
         trig     <= '0;
         imode    <= 1'b0;
         ie       <= '0;
         drq_en   <= 1'b0;
         cs0      <= '0;
         cs1      <= '0;
         tx_count <= '0;
      end else begin
         soft_rst <= we_ctrl & bus_wdata[CTRL_RST];
         flush    <= we_fctl & bus_wdata[FCTL_FLUSH];
         if (we_ctrl) begin
            glob_en <= bus_wdata[CTRL_GEN];
            mclk_oe <= bus_wdata[CTRL_MCLK];
            div_hi  <= bus_wdata[CTRL_DIV_LSB+1 +: DIV_W-1];
         end
         if (we_cfg) tx_cfg <= bus_wdata & CFG_WMASK;
         if (we_fctl) begin
            trig  <= bus_wdata[FCTL_TRIG_LSB +: TRIG_W];
            imode <= bus_wdata[FCTL_IMODE];
         end
         if (we_ien) begin
            drq_en   <= bus_wdata[IRQ_DRQ];
            ie.under <= bus_wdata[IRQ_UND];
            ie.over  <= bus_wdata[IRQ_OVR];
            ie.low   <= bus_wdata[IRQ_LOW];
         end
         if (we_cs0) cs0 <= bus_wdata;
         if (we_cs1) cs1 <= bus_wdata;
         if (soft_rst)    tx_count <= '0;
         else if (we_cnt) tx_count <= bus_wdata[TXCNT_W-1:0];
         else if (pop)    tx_count <= tx_count + TXCNT_W'(1);
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[CTRL_RST]                    = soft_rst;
            bus_rdata[CTRL_GEN]                    = glob_en;
            bus_rdata[CTRL_MCLK]                   = mclk_oe;
            bus_rdata[CTRL_DIV_LSB +: DIV_W]       = mclk_div;
         end
         ADDR_W'(OFS_CFG):  bus_rdata = tx_cfg;
         ADDR_W'(OFS_FCTL): begin
            bus_rdata[FCTL_FLUSH]                  = flush;
            bus_rdata[FCTL_TRIG_LSB +: TRIG_W]     = trig;
            bus_rdata[FCTL_IMODE]                  = imode;
         end
         ADDR_W'(OFS_FSTA): begin
            bus_rdata[FSTA_SPACE]                  = (free != '0);
            bus_rdata[FSTA_FREE_LSB +: FILL_W]     = free;
         end
         ADDR_W'(OFS_IEN): begin
            bus_rdata[IRQ_DRQ] = drq_en;
            bus_rdata[IRQ_UND] = ie.under;
            bus_rdata[IRQ_OVR] = ie.over;
            bus_rdata[IRQ_LOW] = ie.low;
         end
         ADDR_W'(OFS_ISTA): begin
            bus_rdata[IRQ_UND] = sta.under;
            bus_rdata[IRQ_OVR] = sta.over;
            bus_rdata[IRQ_LOW] = sta.low;
         end
         ADDR_W'(OFS_CNT):  bus_rdata[TXCNT_W-1:0] = tx_count;
         ADDR_W'(OFS_CS0):  bus_rdata = cs0;
         ADDR_W'(OFS_CS1):  bus_rdata = cs1;
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/aud_tx_ctrl.sv
`timescale 1ns/1ps
module aud_tx_ctrl
   import aud_tx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned DIV_W    = 4,
   parameter int unsigned TRIG_W   = 5,
   parameter int unsigned TXCNT_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic                dma_we,
   input  logic [15:0]         dma_wdata,
   output logic                dma_req,
   input  logic                enc_pull,
   output logic [SAMPLE_W-1:0] enc_sample,
   output logic                enc_active,
   output logic [31:0]         enc_cfg,
   output logic [31:0]         enc_cs0,
   output logic [31:0]         enc_cs1,
   output logic                mclk_oe,
   output logic [DIV_W-1:0]    mclk_div,
   output logic                irq
);
   localparam int unsigned FILL_W = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 6)                    begin : g_bad_addr  $error("ADDR_W below 6"); end
   if (DEPTH < 2)                     begin : g_bad_depth $error("DEPTH below 2"); end
   if (FILL_W > 6)                    begin : g_bad_fill  $error("DEPTH too large for the free-count field"); end
   if (SAMPLE_W < 16 || SAMPLE_W > 32) begin : g_bad_smp  $error("SAMPLE_W out of range"); end
   if (DIV_W < 2 || DIV_W > 4)        begin : g_bad_div   $error("DIV_W out of range"); end
   if (TRIG_W < 1 || TRIG_W > 5)      begin : g_bad_trig  $error("TRIG_W out of range"); end
   if (TXCNT_W < 1 || TXCNT_W > 32)   begin : g_bad_cnt   $error("TXCNT_W out of range"); end

   logic                glob_en, imode, drq_en, soft_rst, flush, bus_fifo_we;
   logic [TRIG_W-1:0]   trig;
   tx_evt_t             ie, w1c, sta, evt;
   logic [FILL_W-1:0]   fill;
   logic                pop_ok, ovr_p, und_p, low_lvl, tx_active;
   logic                push, clr;
   logic [SAMPLE_W-1:0] dma_word, push_data;
   logic [TXCNT_W-1:0]  tx_count;

   aud_tx_regs #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .FILL_W(FILL_W),
      .DIV_W(DIV_W), .TRIG_W(TRIG_W), .TXCNT_W(TXCNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fill(fill), .sta(sta), .pop(pop_ok),
      .glob_en(glob_en), .mclk_oe(mclk_oe), .mclk_div(mclk_div),
      .tx_cfg(enc_cfg), .trig(trig), .imode(imode), .ie(ie), .drq_en(drq_en),
      .cs0(enc_cs0), .cs1(enc_cs1), .soft_rst(soft_rst), .flush(flush),
      .w1c(w1c), .fifo_we(bus_fifo_we), .tx_count(tx_count)
   );

   // DMA word placement inside the sample
   if (SAMPLE_W > 16) begin : g_wide
      always_comb dma_word = imode ? {{(SAMPLE_W-16){1'b0}}, dma_wdata}
                                   : {dma_wdata, {(SAMPLE_W-16){1'b0}}};
   end else begin : g_narrow
      always_comb dma_word = imode ? dma_wdata : dma_wdata;
   end

   assign push      = dma_we | bus_fifo_we;
   assign push_data = dma_we ? dma_word : bus_wdata[SAMPLE_W-1:0];
   assign clr       = soft_rst | flush;
   assign tx_active = glob_en & enc_cfg[CFG_TXEN];
   assign enc_active = tx_active;

   aud_tx_fifo #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .FILL_W(FILL_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(push), .push_data(push_data),
      .pull(enc_pull & tx_active),
      .head(enc_sample), .fill(fill), .pop_ok(pop_ok),
      .overrun(ovr_p), .underrun(und_p)
   );

   assign low_lvl = (32'(fill) <= 32'(trig));
   assign dma_req = glob_en & drq_en & low_lvl;

   always_comb begin
      evt.under = und_p;
      evt.over  = ovr_p;
      evt.low   = low_lvl;
   end

   aud_tx_irq u_irq (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .evt(evt), .w1c(w1c), .ie(ie), .sta(sta), .irq(irq)
   );
endmodule

// File: rtl/aud_tx_chk.sv
`timescale 1ns/1ps
module aud_tx_chk
   import aud_tx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned FILL_W   = 6,
   parameter int unsigned TXCNT_W  = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                soft_rst,
   input logic                flush,
   input logic                push,
   input logic                enc_pull,
   input logic                enc_active,
   input logic [SAMPLE_W-1:0] enc_sample,
   input logic [FILL_W-1:0]   fill,
   input logic                pop_ok,
   input tx_evt_t             sta,
   input logic [TXCNT_W-1:0]  tx_count
);
   logic cnt_we;
   assign cnt_we = bus_we && (bus_addr == ADDR_W'(OFS_CNT));

   p_softrst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (fill == '0 && sta == '0 && tx_count == '0));

   p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill == '0));

   p_pull_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_active |-> !pop_ok);

   p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));

   p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && fill == FILL_W'(DEPTH) && !pop_ok && !soft_rst && !flush) |=> sta.over);

   p_underrun_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_pull && enc_active && fill == '0) |-> (enc_sample == '0));

   p_underrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_pull && enc_active && fill == '0 && !soft_rst && !flush) |=> sta.under);

   p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !soft_rst && !cnt_we) |=> (tx_count == $past(tx_count) + TXCNT_W'(1)));
endmodule

bind aud_tx_ctrl aud_tx_chk #(
   .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W),
   .FILL_W(FILL_W), .TXCNT_W(TXCNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .soft_rst(soft_rst), .flush(flush), .push(push),
   .enc_pull(enc_pull), .enc_active(enc_active), .enc_sample(enc_sample),
   .fill(fill), .pop_ok(pop_ok), .sta(sta), .tx_count(tx_count)
);

// File: tb/tb_aud_tx_ctrl.sv
`timescale 1ns/100ps
module tb_aud_tx_ctrl;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned SW     = 24;
   localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_FIFO = 8'h0C, A_FCTL = 8'h14,
                          A_FSTA = 8'h18, A_IEN = 8'h1C, A_ISTA = 8'h20, A_CNT = 8'h24,
                          A_CS0 = 8'h2C, A_CS1 = 8'h30;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              dma_we = 1'b0;
   logic [15:0]       dma_wdata = '0;
   logic              dma_req;
   logic              enc_pull = 1'b0;
   logic [SW-1:0]     enc_sample;
   logic              enc_active;
   logic [31:0]       enc_cfg, enc_cs0, enc_cs1;
   logic              mclk_oe;
   logic [3:0]        mclk_div;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   aud_tx_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_we(dma_we),
      .dma_wdata(dma_wdata), .dma_req(dma_req), .enc_pull(enc_pull),
      .enc_sample(enc_sample), .enc_active(enc_active), .enc_cfg(enc_cfg),
      .enc_cs0(enc_cs0), .enc_cs1(enc_cs1), .mclk_oe(mclk_oe),
      .mclk_div(mclk_div), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      peek(a, d);
   endtask

   task automatic dma(input logic [15:0] d);
      @(negedge clk);
      dma_we = 1'b1; dma_wdata = d;
      @(negedge clk);
      dma_we = 1'b0;
   endtask

   task automatic pull_one(output logic [SW-1:0] s);
      @(negedge clk);
      s = enc_sample;
      enc_pull = 1'b1;
      @(negedge clk);
      enc_pull = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
      rd(A_CFG, d);  chk("R1 cfg", d, 32'h0);
      rd(A_FSTA, d); chk("R1 fsta", d, 32'h6000);
      rd(A_ISTA, d); chk("R1 ista", d, 32'h10);
      rd(A_CNT, d);  chk("R1 cnt", d, 32'h0);
      chk("R1 pins", {29'd0, dma_req, irq, |enc_sample}, 32'h0);
   endtask

   task automatic t_ctrl;
      logic [31:0] d;
      wr(A_CTRL, 32'h36);
      rd(A_CTRL, d); chk("R2 odd divider rounded", d, 32'h26);
      chk("R2 mclk pins", {27'd0, mclk_oe, mclk_div}, {27'd0, 1'b1, 4'h2});
   endtask

   task automatic t_cfg_cs;
      logic [31:0] d;
      wr(A_CFG, 32'hFFFF_FFFF);
      rd(A_CFG, d); chk("R14 cfg mask", d, 32'h8003_01FF);
      chk("R14 cfg port", enc_cfg, 32'h8003_01FF);
      wr(A_CS0, 32'hA5A5_1234);
      wr(A_CS1, 32'h0000_00F1);
      rd(A_CS0, d); chk("R14 cs0", d, 32'hA5A5_1234);
      chk("R14 cs ports", enc_cs0 ^ enc_cs1, 32'hA5A5_1234 ^ 32'h0000_00F1);
   endtask

   task automatic t_fifo_path;
      logic [31:0] d;
      logic [SW-1:0] s;
      logic [SW-1:0] exp_q [4];
      exp_q[0] = 24'hBEEF00; exp_q[1] = 24'h001234; exp_q[2] = 24'hABCDEF; exp_q[3] = 24'h005555;
      wr(A_CTRL, 32'h0); wr(A_CFG, 32'h0); wr(A_FCTL, 32'h0);
      dma(16'hBEEF);
      wr(A_FCTL, 32'h4);
      dma(16'h1234);
      wr(A_FIFO, 32'hFFAB_CDEF);
      @(negedge clk);
      dma_we = 1'b1; dma_wdata = 16'h5555;
      bus_we = 1'b1; bus_addr = A_FIFO; bus_wdata = 32'h0077_7777;
      @(negedge clk);
      dma_we = 1'b0; bus_we = 1'b0;
      rd(A_FSTA, d); chk("R7 free count 28", d, 32'h5C00);
      @(negedge clk); enc_pull = 1'b1;
      @(negedge clk); enc_pull = 1'b0;
      rd(A_FSTA, d); chk("R6 pull ignored when disabled", d, 32'h5C00);
      rd(A_CNT, d);  chk("R6 counter untouched when disabled", d, 32'h0);
      wr(A_CFG, 32'h1); wr(A_CTRL, 32'h2);
      for (int i = 0; i < 4; i++) begin
         pull_one(s);
         chk("R5 R6 sample order/alignment", {8'd0, s}, {8'd0, exp_q[i]});
      end
      rd(A_CNT, d); chk("R13 count after 4 pulls", d, 32'd4);
   endtask

   task automatic t_underrun_irq;
      logic [31:0] d;
      logic [SW-1:0] s;
      pull_one(s);
      chk("R10 underrun sample zero", {8'd0, s}, 32'h0);
      rd(A_ISTA, d); chk("R10 underrun flag", d, 32'h50);
      rd(A_CNT, d);  chk("R10 counter unchanged", d, 32'd4);
      wr(A_IEN, 32'h40);
      chk("R12 irq on enabled underrun", {31'd0, irq}, 32'h1);
      wr(A_ISTA, 32'h40);
      rd(A_ISTA, d); chk("R11 write-one clears", d, 32'h10);
      chk("R12 irq drops", {31'd0, irq}, 32'h0);
      wr(A_ISTA, 32'h10);
      rd(A_ISTA, d); chk("R11 set wins over clear", d, 32'h10);
      wr(A_CNT, 32'h0);
      rd(A_CNT, d); chk("R13 counter cleared", d, 32'h0);
      wr(A_CNT, 32'h7);
      rd(A_CNT, d); chk("R13 counter loaded", d, 32'h7);
   endtask

   task automatic t_overrun;
      logic [31:0] d;
      logic [SW-1:0] s;
      wr(A_CTRL, 32'h0);
      for (int i = 0; i < 32; i++) dma(16'h0100 + 16'(i));
      rd(A_FSTA, d); chk("R7 full reads no space", d, 32'h0);
      dma(16'h0AAA);
      rd(A_ISTA, d); chk("R9 overrun flag", d & 32'h20, 32'h20);
      wr(A_ISTA, 32'h20);
      wr(A_CTRL, 32'h2);
      @(negedge clk);
      s = enc_sample;
      dma_we = 1'b1; dma_wdata = 16'h0BBB; enc_pull = 1'b1;
      @(negedge clk);
      dma_we = 1'b0; enc_pull = 1'b0;
      chk("R9 head at full", {8'd0, s}, 32'h100);
      rd(A_ISTA, d); chk("R9 no overrun with pull", d & 32'h20, 32'h0);
      rd(A_FSTA, d); chk("R9 still full", d, 32'h0);
      chk("R9 discarded word absent", {8'd0, enc_sample}, 32'h101);
   endtask

   task automatic t_flush;
      logic [31:0] d;
      wr(A_CTRL, 32'h0);
      rd(A_CNT, d); chk("R13 count kept running", d, 32'd8);
      wr(A_FCTL, 32'h2_0004);
      peek(A_FCTL, d); chk("R4 flush bit pulse", d, 32'h2_0004);
      rd(A_FCTL, d); chk("R4 flush self-clears", d, 32'h4);
      rd(A_FSTA, d); chk("R4 FIFO emptied", d, 32'h6000);
      rd(A_CNT, d);  chk("R4 counter kept", d, 32'd8);
   endtask

   task automatic t_dreq;
      logic [SW-1:0] s;
      wr(A_FCTL, 32'h404);
      wr(A_IEN, 32'h80);
      wr(A_CTRL, 32'h2);
      chk("R8 request at low level", {31'd0, dma_req}, 32'h1);
      for (int i = 0; i < 5; i++) dma(16'h0200 + 16'(i));
      chk("R8 request off above level", {31'd0, dma_req}, 32'h0);
      pull_one(s);
      chk("R8 request back at level", {31'd0, dma_req}, 32'h1);
      wr(A_CTRL, 32'h0);
      chk("R8 global gate", {31'd0, dma_req}, 32'h0);
   endtask

   task automatic t_softrst;
      logic [31:0] d;
      wr(A_CTRL, 32'h23);
      rd(A_ISTA, d); chk("R3 status cleared", d, 32'h0);
      rd(A_FSTA, d); chk("R3 FIFO emptied", d, 32'h6000);
      rd(A_CNT, d);  chk("R3 counter cleared", d, 32'h0);
      rd(A_CTRL, d); chk("R3 reset bit self-clears, rest kept", d, 32'h22);
      rd(A_FCTL, d); chk("R3 FIFO control kept", d, 32'h404);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_ctrl();
      t_cfg_cs();
      t_fifo_path();
      t_underrun_irq();
      t_overrun();
      t_flush();
      t_dreq();
      t_softrst();
      finish_run();
   end
endmodule